// File: doc/BRIEF.md
# Power-Supply Controller I2C Register Bank

This block is the serial control port of a satellite-dish supply controller. It answers a two-wire I2C bus as a slave, keeps four read/write control bytes that set the output voltage code, the tone source, the current-limit style and the fault-recovery style, and presents three sticky fault flags in a read-only status byte. Control fields leave the block as plain outputs. The neighbouring protection and regulator logic reads these outputs directly.

The bus lines are synchronised to a fast system clock and decoded by oversampling. A host first sets an internal register pointer with a write frame. It then either streams data bytes, with the pointer stepping after each byte, or ends the frame and re-addresses the part for reading. Read data then streams out from the pointer for as long as the host acknowledges. Fault flags stay set after their cause disappears and are dropped only once the host has been shown them. While the supply is below its lockout level, the slave is deaf and mute and every byte it holds is zero. The protection logic can also zero the voltage code through a request input.

Top module: `psu_i2c_regbank`

## Requirements
- R1: The slave answers only the 7-bit address 0001000 when `addr_sel_i` is low and 0001001 when it is high. The 8th bit of the address byte is the direction (1 = read). Any other address gets no ACK and changes nothing.
- R2: Register index 0 is the status byte and index 1 is a second status byte that reads 0. Both are read-only, and writes to them are dropped. Indices 2..5 are control bytes C0..C3 that read back the last value written. Indices above 5 read 0 and ignore writes.
- R3: In a write frame, the slave ACKs the address byte, the index byte and every data byte. Each data byte goes to the current index, and the index then steps by one.
- R4: A read frame returns bytes starting at the index left by the previous frame. Each byte is sent MSB first. The slave goes on with the next index while the host ACKs and releases SDA after a host NACK.
- R5: After reset, every control byte, every flag and every field output is 0.
- R6: While `uv_i` is high, the slave never pulls SDA low, ignores all bus traffic, and holds all control bytes and flags at 0.
- R7: The flags are `diag_flags_o[0]` overload (status bit 0), `[1]` over-temperature (status bit 6) and `[2]` supply-not-good (status bit 7). Each flag sets while its cause input is high and stays set after the cause drops. A flag clears when the status byte that showed it as 1 completes its ACK/NACK bit to the host, and only if the cause is low at that moment.
- R8: The field outputs are: `vsel_o` = C0[3:0]; `tone_en_o` = C1[0]; `ext_tone_o` = C1[2]; `pulse_lim_off_o` = C2[2]; `ovl_latch_o` = C3[3]; `temp_latch_o` = C3[6]; `comp_ceramic_o` = C3[7].
- R9: A cycle with `vsel_clr_i` high zeroes C0[3:0] and leaves C0[7:4] untouched. This request overrides a write to C0 in the same cycle.
- R10: A STOP or START that arrives part-way through a byte abandons that byte and leaves every register unchanged. A START then begins a fresh address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20x the bus bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain drive) |
| addr_sel_i | input | 1 | Strap choosing the address low bit |
| uv_i | input | 1 | Supply below lockout level |
| ovl_fault_i | input | 1 | Overload cause, synchronous to clk |
| temp_fault_i | input | 1 | Over-temperature cause, synchronous to clk |
| supply_fault_i | input | 1 | Input-supply-low cause, synchronous to clk |
| vsel_clr_i | input | 1 | Protection request to zero the voltage code |
| vsel_o | output | 4 | Output voltage code |
| tone_en_o | output | 1 | Tone enable |
| ext_tone_o | output | 1 | Tone pin carries a full external carrier |
| pulse_lim_off_o | output | 1 | Static current clamp instead of pulsed limiting |
| ovl_latch_o | output | 1 | Overload recovery waits for host |
| temp_latch_o | output | 1 | Thermal recovery waits for host |
| comp_ceramic_o | output | 1 | Converter loop tuned for ceramic capacitors |
| diag_flags_o | output | 3 | Sticky flags {supply, temperature, overload} |

## Verification
The hardest case to reach is a flag whose cause is still high when its status byte finishes on the bus, followed by a later read after the cause has gone. The stimulus holds a fault input high across a full read frame and checks that the flag survives. It then drops the cause and checks that the flag still survives until a second status read completes. A second awkward case is a frame cut off in the middle of a data byte. A bit-level task sends only part of a byte before a STOP or a new START, and a readback confirms that nothing moved.

// File: rtl/psu_i2c_pkg.sv
// Package: shared constants and types for the supply-controller I2C register bank.
// Assumes an 8-bit register index and byte-wide registers.
package psu_i2c_pkg;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned N_CTL    = 4;
    localparam int unsigned N_FLAGS  = 3;
    localparam int unsigned BIT_CNT_W = 4;

    // upper six bits of the 7-bit slave address; the strap supplies bit 0
    localparam logic [5:0] DEV_ADDR_HI = 6'b000100;

    localparam logic [BYTE_W-1:0] IDX_STAT0 = 8'd0;
    localparam logic [BYTE_W-1:0] IDX_STAT1 = 8'd1;
    localparam logic [BYTE_W-1:0] IDX_CTL0  = 8'd2;
    localparam logic [BYTE_W-1:0] IDX_CTL3  = IDX_CTL0 + 8'(N_CTL - 1);

    // status-byte bit position of each flag: overload, temperature, supply
    localparam int unsigned FLAG_BIT [N_FLAGS] = '{0, 6, 7};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } bus_state_t;

    typedef enum logic [1:0] {
        K_DEV,
        K_IDX,
        K_DATA
    } byte_kind_t;

endpackage

// File: rtl/psu_i2c_sync.sv
// Module: brings SCL/SDA into the clk domain and flags bus events.
// Assumes clk runs at least ~20x the bus bit rate. Lines idle high.
module psu_i2c_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;

    // metastability chains for both lines
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    // one-cycle history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/psu_i2c_fsm.sv
// Module: byte-level slave sequencer (address match, ACK, index, data in/out).
// Assumes bus events come from psu_i2c_sync. Read data is combinational from the register file.
module psu_i2c_fsm
    import psu_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uv_i,
    input  logic              addr_sel_i,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              wr_stb,
    output logic              rd_stb,
    output logic [BYTE_W-1:0] idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] sent_byte
);

    bus_state_t           state;
    byte_kind_t           kind;
    logic [BIT_CNT_W-1:0] bitcnt;
    logic [BYTE_W-1:0]    rx_sh;
    logic [BYTE_W-1:0]    tx_sh;
    logic                 is_read;
    logic                 host_ack;
    logic                 byte_done;

    assign byte_done = (state == ST_RX) && scl_fall && (bitcnt == BIT_CNT_W'(BYTE_W));

    // protocol sequencer: one state per bus phase
    always_ff @(posedge clk) begin
        if (!rst_n || uv_i) begin
            state     <= ST_IDLE;
            kind      <= K_DEV;
            bitcnt    <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            sent_byte <= '0;
            idx       <= '0;
            is_read   <= 1'b0;
            host_ack  <= 1'b0;
        end else if (stop_det) begin
            state <= ST_IDLE;
        end else if (start_det) begin
            state  <= ST_RX;
            kind   <= K_DEV;
            bitcnt <= '0;
        end else begin
            case (state)
                ST_RX: begin
                    if (scl_rise) begin
                        rx_sh  <= {rx_sh[BYTE_W-2:0], sda_s};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_done) begin
                        case (kind)
                            K_DEV: begin
                                if (rx_sh[7:1] == {DEV_ADDR_HI, addr_sel_i}) begin
                                    is_read <= rx_sh[0];
                                    state   <= ST_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end
                            K_IDX: begin
                                idx   <= rx_sh;
                                state <= ST_ACK;
                            end
                            default: begin
                                idx   <= idx + 1'b1;
                                state <= ST_ACK;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        if (is_read) begin
                            tx_sh     <= rd_data;
                            sent_byte <= rd_data;
                            state     <= ST_TX;
                        end else begin
                            state <= ST_RX;
                            kind  <= (kind == K_DEV) ? K_IDX : K_DATA;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (bitcnt == BIT_CNT_W'(BYTE_W - 1)) begin
                            state <= ST_MACK;
                        end else begin
                            tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        host_ack <= ~sda_s;
                        idx      <= idx + 1'b1;
                    end else if (scl_fall) begin
                        if (host_ack) begin
                            tx_sh     <= rd_data;
                            sent_byte <= rd_data;
                            bitcnt    <= '0;
                            state     <= ST_TX;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign sda_oe  = (state == ST_ACK) || ((state == ST_TX) && !tx_sh[BYTE_W-1]);
    assign wr_stb  = byte_done && (kind == K_DATA) && !start_det && !stop_det;
    assign rd_stb  = (state == ST_MACK) && scl_rise && !start_det && !stop_det;
    assign wr_data = rx_sh;

    AST_SILENT_IN_UV: assert property (@(posedge clk) disable iff (!rst_n)
        uv_i |=> !sda_oe); // R6
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_oe && !wr_stb)); // R10
    AST_NO_STROBE_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && rd_stb)); // R3
    AST_IDX_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !uv_i) |=> (idx == $past(idx) + 8'd1)); // R3

endmodule

// File: rtl/psu_i2c_regs.sv
// Module: control bytes, sticky fault flags and the read mux.
// Assumes fault causes are synchronous to clk. Strobes come from psu_i2c_fsm.
module psu_i2c_regs
    import psu_i2c_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               uv_i,
    input  logic               wr_stb,
    input  logic               rd_stb,
    input  logic [BYTE_W-1:0]  idx,
    input  logic [BYTE_W-1:0]  wr_data,
    input  logic [BYTE_W-1:0]  sent_byte,
    input  logic [N_FLAGS-1:0] cause,
    input  logic               vsel_clr,
    output logic [BYTE_W-1:0]  rd_data,
    output logic [BYTE_W-1:0]  ctl [N_CTL],
    output logic [N_FLAGS-1:0] flags
);

    logic [BYTE_W-1:0] status;
    logic              ctl_hit;
    logic              stat_done;

    assign ctl_hit   = (idx >= IDX_CTL0) && (idx <= IDX_CTL3);
    assign stat_done = rd_stb && (idx == IDX_STAT0);

    // control bytes: host writes, protection clear of the voltage code wins
    always_ff @(posedge clk) begin
        if (!rst_n || uv_i) begin
            for (int i = 0; i < N_CTL; i++) ctl[i] <= '0;
        end else begin
            if (wr_stb && ctl_hit) ctl[2'(idx - IDX_CTL0)] <= wr_data;
            if (vsel_clr) ctl[0][3:0] <= 4'h0;
        end
    end

    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
        // sticky flag: set by cause, cleared once reported and cause gone
        always_ff @(posedge clk) begin
            if (!rst_n || uv_i)
                flags[g] <= 1'b0;
            else if (cause[g])
                flags[g] <= 1'b1;
            else if (stat_done && sent_byte[FLAG_BIT[g]])
                flags[g] <= 1'b0;
        end

        AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            (cause[g] && !uv_i) |=> flags[g]); // R7
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[g] && !uv_i && !stat_done) |=> flags[g]); // R7
    end

    // status byte assembly
    always_comb begin
        status = '0;
        for (int i = 0; i < N_FLAGS; i++) status[FLAG_BIT[i]] = flags[i];
    end

    // read mux by current index
    always_comb begin
        if (idx == IDX_STAT0)
            rd_data = status;
        else if (ctl_hit)
            rd_data = ctl[2'(idx - IDX_CTL0)];
        else
            rd_data = '0;
    end

    AST_UV_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        uv_i |=> (ctl[0] == 8'h00 && ctl[1] == 8'h00 && ctl[2] == 8'h00
                  && ctl[3] == 8'h00 && flags == '0)); // R6
    AST_VSEL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (vsel_clr && !uv_i) |=> (ctl[0][3:0] == 4'h0)); // R9
    AST_VSEL_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (vsel_clr && !uv_i && !(wr_stb && idx == IDX_CTL0)) |=> $stable(ctl[0][7:4])); // R9
    AST_STATUS_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && idx == IDX_STAT0 && cause == '0 && !rd_stb && !uv_i) |=> $stable(flags)); // R2

endmodule

// File: rtl/psu_i2c_regbank.sv
// Module: top of the supply-controller I2C register bank.
// Assumes SDA is wired open-drain outside (sda_oe_o high = pull low).
module psu_i2c_regbank
    import psu_i2c_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic       addr_sel_i,
    input  logic       uv_i,
    input  logic       ovl_fault_i,
    input  logic       temp_fault_i,
    input  logic       supply_fault_i,
    input  logic       vsel_clr_i,
    output logic [3:0] vsel_o,
    output logic       tone_en_o,
    output logic       ext_tone_o,
    output logic       pulse_lim_off_o,
    output logic       ovl_latch_o,
    output logic       temp_latch_o,
    output logic       comp_ceramic_o,
    output logic [2:0] diag_flags_o
);

    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_stb, rd_stb;
    logic [BYTE_W-1:0] idx, wr_data, sent_byte, rd_data;
    logic [BYTE_W-1:0] ctl [N_CTL];
    logic [N_FLAGS-1:0] flags;

    psu_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    psu_i2c_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .uv_i(uv_i), .addr_sel_i(addr_sel_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .rd_data(rd_data),
        .sda_oe(sda_oe_o), .wr_stb(wr_stb), .rd_stb(rd_stb), .idx(idx),
        .wr_data(wr_data), .sent_byte(sent_byte)
    );

    psu_i2c_regs u_regs (
        .clk(clk), .rst_n(rst_n), .uv_i(uv_i), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .idx(idx), .wr_data(wr_data), .sent_byte(sent_byte),
        .cause({supply_fault_i, temp_fault_i, ovl_fault_i}),
        .vsel_clr(vsel_clr_i), .rd_data(rd_data), .ctl(ctl), .flags(flags)
    );

    assign vsel_o          = ctl[0][3:0];
    assign tone_en_o       = ctl[1][0];
    assign ext_tone_o      = ctl[1][2];
    assign pulse_lim_off_o = ctl[2][2];
    assign ovl_latch_o     = ctl[3][3];
    assign temp_latch_o    = ctl[3][6];
    assign comp_ceramic_o  = ctl[3][7];
    assign diag_flags_o    = flags;

endmodule

// File: tb/psu_i2c_regbank_bench.sv
`timescale 1ns/1ps
module psu_i2c_regbank_bench;

    localparam real TQ = 100.0;  // quarter of a bus bit, ns

    // {index, write data, expected readback}
    localparam logic [23:0] VEC [8] = '{
        24'h020F0F, 24'h030505, 24'h040404, 24'h05C8C8,
        24'h00FF00, 24'h01FF00, 24'h06AA00, 24'h02A3A3
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic addr_sel = 1'b0;
    logic uv = 1'b0;
    logic f_ovl = 1'b0, f_tmp = 1'b0, f_sup = 1'b0;
    logic vclr = 1'b0;
    logic sda_oe;
    logic [3:0] vsel;
    logic tone_en, ext_tone, plim_off, ovl_latch, temp_latch, comp_cer;
    logic [2:0] flags;
    wire  sda_line = sda_m & ~sda_oe;

    int total = 0;
    int bad = 0;
    logic [6:0] dev = 7'b0001000;
    logic [7:0] rbuf [8];
    logic [7:0] shadow [4];
    logic ok;

    always #2.5 clk = ~clk;

    psu_i2c_regbank u_psu_i2c_regbank (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .addr_sel_i(addr_sel), .uv_i(uv), .ovl_fault_i(f_ovl), .temp_fault_i(f_tmp),
        .supply_fault_i(f_sup), .vsel_clr_i(vclr), .vsel_o(vsel), .tone_en_o(tone_en),
        .ext_tone_o(ext_tone), .pulse_lim_off_o(plim_off), .ovl_latch_o(ovl_latch),
        .temp_latch_o(temp_latch), .comp_ceramic_o(comp_cer), .diag_flags_o(flags)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] fields_exp();
        return {shadow[0][3:0], shadow[1][0], shadow[1][2], shadow[2][2],
                shadow[3][3], shadow[3][6], shadow[3][7]};
    endfunction

    function automatic logic [9:0] fields_act();
        return {vsel, tone_en, ext_tone, plim_off, ovl_latch, temp_latch, comp_cer};
    endfunction

    task automatic b_start();
        sda_m = 1'b1; #(TQ); scl_m = 1'b1; #(TQ); sda_m = 1'b0; #(TQ); scl_m = 1'b0; #(TQ);
    endtask

    task automatic b_stop();
        sda_m = 1'b0; #(TQ); scl_m = 1'b1; #(TQ); sda_m = 1'b1; #(TQ);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; #(TQ); scl_m = 1'b1; #(TQ); scl_m = 1'b0; #(TQ);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; #(TQ); scl_m = 1'b1; #(TQ/2); ack = ~sda_line; #(TQ/2);
        scl_m = 1'b0; #(TQ);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; #(TQ); scl_m = 1'b1; #(TQ/2); b[i] = sda_line; #(TQ/2);
            scl_m = 1'b0; #(TQ);
        end
        sda_m = ~give_ack; #(TQ); scl_m = 1'b1; #(TQ); scl_m = 1'b0; sda_m = 1'b1; #(TQ);
    endtask

    task automatic wr_reg(input logic [7:0] r, input logic [7:0] d, output logic acked);
        logic a0, a1, a2;
        b_start();
        send_byte({dev, 1'b0}, a0);
        send_byte(r, a1);
        send_byte(d, a2);
        b_stop();
        acked = a0 & a1 & a2;
    endtask

    task automatic rd_regs(input logic [7:0] r, input int n);
        logic a;
        b_start(); send_byte({dev, 1'b0}, a); send_byte(r, a); b_stop();
        b_start(); send_byte({dev, 1'b1}, a);
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
        b_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic a;
        for (int i = 0; i < 4; i++) shadow[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R5: reset values
        chk("R5 fields", {6'd0, fields_act()}, 16'h0000);
        chk("R5 flags", {13'd0, flags}, 16'h0000);
        rd_regs(8'h00, 6);
        for (int i = 0; i < 6; i++) chk("R5 R4 reg readback", {8'd0, rbuf[i]}, 16'h0000);

        // R2 R8: vector table of write then readback
        for (int i = 0; i < 8; i++) begin
            wr_reg(VEC[i][23:16], VEC[i][15:8], ok);
            chk("R3 write acked", {15'd0, ok}, 16'h0001);
            if (VEC[i][23:16] >= 8'd2 && VEC[i][23:16] <= 8'd5)
                shadow[VEC[i][17:16] + 2'd2] = VEC[i][15:8];
            rd_regs(VEC[i][23:16], 1);
            chk("R2 readback", {8'd0, rbuf[0]}, {8'd0, VEC[i][7:0]});
            chk("R8 fields", {6'd0, fields_act()}, {6'd0, fields_exp()});
        end

        // R3 R4 R8: burst write with auto-increment, burst read
        b_start();
        send_byte({dev, 1'b0}, a); chk("R3 addr ack", {15'd0, a}, 16'h0001);
        send_byte(8'h02, a);       chk("R3 index ack", {15'd0, a}, 16'h0001);
        send_byte(8'h03, a);       chk("R3 data0 ack", {15'd0, a}, 16'h0001);
        send_byte(8'h01, a);       chk("R3 data1 ack", {15'd0, a}, 16'h0001);
        send_byte(8'h04, a);       chk("R3 data2 ack", {15'd0, a}, 16'h0001);
        send_byte(8'h88, a);       chk("R3 data3 ack", {15'd0, a}, 16'h0001);
        b_stop();
        shadow[0] = 8'h03; shadow[1] = 8'h01; shadow[2] = 8'h04; shadow[3] = 8'h88;
        chk("R8 burst fields", {6'd0, fields_act()}, {6'd0, fields_exp()});
        rd_regs(8'h02, 4);
        chk("R4 burst rd0", {8'd0, rbuf[0]}, 16'h0003);
        chk("R4 burst rd1", {8'd0, rbuf[1]}, 16'h0001);
        chk("R4 burst rd2", {8'd0, rbuf[2]}, 16'h0004);
        chk("R4 burst rd3", {8'd0, rbuf[3]}, 16'h0088);
        chk("R4 sda released", {15'd0, sda_oe}, 16'h0000);

        // R1: address decode with strap
        dev = 7'b0001001;
        wr_reg(8'h03, 8'h05, ok);
        chk("R1 wrong address no ack", {15'd0, ok}, 16'h0000);
        chk("R1 wrong address no effect", {15'd0, tone_en}, 16'h0001);
        chk("R1 wrong address ext", {15'd0, ext_tone}, 16'h0000);
        addr_sel = 1'b1;
        #(TQ);
        wr_reg(8'h03, 8'h05, ok);
        chk("R1 strap high ack", {15'd0, ok}, 16'h0001);
        chk("R1 strap high write", {15'd0, ext_tone}, 16'h0001);
        dev = 7'b0001000;
        wr_reg(8'h03, 8'h00, ok);
        chk("R1 low address ignored", {15'd0, ok}, 16'h0000);
        addr_sel = 1'b0;
        #(TQ);

        // R7: sticky flags
        @(negedge clk); f_ovl = 1'b1; @(negedge clk); f_ovl = 1'b0;
        @(negedge clk);
        chk("R7 overload latched", {13'd0, flags}, 16'h0001);
        rd_regs(8'h00, 1);
        chk("R7 status shows overload", {8'd0, rbuf[0]}, 16'h0001);
        chk("R7 overload cleared", {13'd0, flags}, 16'h0000);
        f_tmp = 1'b1;
        #(TQ);
        rd_regs(8'h00, 1);
        chk("R7 status shows temp", {8'd0, rbuf[0]}, 16'h0040);
        chk("R7 temp kept while cause high", {13'd0, flags}, 16'h0002);
        f_tmp = 1'b0;
        #(TQ);
        chk("R7 temp sticky after cause", {13'd0, flags}, 16'h0002);
        rd_regs(8'h00, 1);
        chk("R7 temp reported", {8'd0, rbuf[0]}, 16'h0040);
        chk("R7 temp cleared", {13'd0, flags}, 16'h0000);
        @(negedge clk); f_sup = 1'b1; f_ovl = 1'b1; @(negedge clk); f_sup = 1'b0; f_ovl = 1'b0;
        rd_regs(8'h00, 1);
        chk("R7 supply and overload bits", {8'd0, rbuf[0]}, 16'h0081);
        chk("R7 both cleared", {13'd0, flags}, 16'h0000);

        // R9: protection clear of voltage code
        wr_reg(8'h02, 8'hA5, ok);
        @(negedge clk); vclr = 1'b1; @(negedge clk); vclr = 1'b0;
        @(negedge clk);
        chk("R9 vsel zeroed", {12'd0, vsel}, 16'h0000);
        rd_regs(8'h02, 1);
        chk("R9 upper bits kept", {8'd0, rbuf[0]}, 16'h00A0);

        // R10: STOP and START inside a byte
        wr_reg(8'h04, 8'h04, ok);
        b_start(); send_byte({dev, 1'b0}, a); send_byte(8'h04, a);
        send_bits(8'hFF, 4); b_stop();
        chk("R10 stop mid-byte", {15'd0, plim_off}, 16'h0001);
        b_start(); send_byte({dev, 1'b0}, a); send_byte(8'h04, a);
        send_bits(8'h00, 3);
        rd_regs(8'h04, 1);
        chk("R10 start mid-byte", {8'd0, rbuf[0]}, 16'h0004);

        // R6: undervoltage lockout
        wr_reg(8'h03, 8'h05, ok);
        @(negedge clk); uv = 1'b1;
        repeat (3) @(negedge clk);
        chk("R6 fields zero in uv", {6'd0, fields_act()}, 16'h0000);
        wr_reg(8'h03, 8'h05, ok);
        chk("R6 no ack in uv", {15'd0, ok}, 16'h0000);
        f_ovl = 1'b1;
        repeat (3) @(negedge clk);
        chk("R6 flags held zero", {13'd0, flags}, 16'h0000);
        f_ovl = 1'b0;
        uv = 1'b0;
        repeat (3) @(negedge clk);
        rd_regs(8'h03, 1);
        chk("R6 register stays zero", {8'd0, rbuf[0]}, 16'h0000);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule